// File: doc/BRIEF.md
# Early direction bus timing generator

This block sequences one bus machine cycle over eight clocks on a bus whose read and write lines do not validate anything. They only announce the direction of the coming transfer, and they rise a fixed number of clocks before it. A separate one-clock transfer pulse starts the transfer and marks the lower address byte as valid. Peripherals can use the early direction line to prepare, and use the pulse to act.

A request is taken only when no cycle is running. The block latches a 16-bit address and a direction. The 8-bit address bus carries the upper byte first, together with its own strobe. It then switches to the lower byte and holds it until the next cycle replaces it. On a read, one byte of input data is captured on the clock edge that ends the transfer pulse.

Top module: `early_dir_bus`

## Requirements
- R1: When no cycle is running, a clock edge with `cyc_req` high starts a cycle and latches `cyc_addr` and `cyc_wr` (1 = write, 0 = read). While a cycle runs, `cyc_req` and any change of `cyc_addr` or `cyc_wr` have no effect.
- R2: A cycle occupies eight consecutive clocks, counted 0 to 7 starting with the clock after the accepting edge. The block is idle again after count 7.
- R3: During counts 0 and 1, `bus_ad` carries address bits 15:8. `hi_stb` is high during count 1 only.
- R4: From count 2 to the end of the cycle, `bus_ad` carries address bits 7:0, and it keeps that byte while idle until the next cycle. This means the byte has been stable for more than 3 clocks when the transfer pulse rises.
- R5: `xfer_pulse` is high for exactly one clock per cycle, at count 6.
- R6: In a read cycle, `rd_line` is high from count 1 through count 7, which is 5 clocks before the pulse. `wr_line` stays low.
- R7: In a write cycle, `wr_line` is high from count 4 through count 7, which is 2 clocks before the pulse. `rd_line` stays low.
- R8: `rd_line` and `wr_line` are never high together. Both are low whenever no cycle is running.
- R9: In a read cycle, `rd_data` takes `rd_in` on the clock edge that ends count 6. At all other times, and in write cycles, `rd_data` holds its value.
- R10: After reset the block is idle, and `bus_ad`, `hi_stb`, `rd_line`, `wr_line`, `xfer_pulse` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_req | input | 1 | Request to start a machine cycle |
| cyc_wr | input | 1 | Direction of the requested cycle, 1 = write |
| cyc_addr | input | 16 | Address of the requested cycle |
| rd_in | input | 8 | Data returned by the peripheral |
| bus_ad | output | 8 | Time-multiplexed address byte |
| hi_stb | output | 1 | Marks the upper address byte |
| rd_line | output | 1 | Early read direction |
| wr_line | output | 1 | Early write direction |
| xfer_pulse | output | 1 | Transfer pulse, qualifies the lower byte |
| rd_data | output | 8 | Captured read data |

## Verification
Reads and writes alternate over addresses that are all zeros, all ones, mixed, and with equal upper and lower bytes. The equal-byte case shows whether the lower-byte stability check depends on a visible change on the bus. The length of each direction line's run before the pulse tells a read-timed line from a write-timed one. The input data is inverted on every edge except the capture edge, so a capture one clock early or late is exposed. A request raised in the middle of a cycle, and the address inputs changing during a cycle, show whether the latch and the idle-only acceptance are correct. A request held high across two cycles shows a second cycle starting straight after the first.

// File: rtl/early_dir_bus.sv
module early_dir_bus #(
  parameter int ADDR_W  = 16,
  parameter int CYC_LEN = 8,
  parameter int HI_SLOTS = 2,
  parameter int XFER_AT = 6,
  parameter int RD_LEAD = 5,
  parameter int WR_LEAD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_req,
  input  logic                cyc_wr,
  input  logic [ADDR_W-1:0]   cyc_addr,
  input  logic [ADDR_W/2-1:0] rd_in,
  output logic [ADDR_W/2-1:0] bus_ad,
  output logic                hi_stb,
  output logic                rd_line,
  output logic                wr_line,
  output logic                xfer_pulse,
  output logic [ADDR_W/2-1:0] rd_data
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int CNT_W  = $clog2(CYC_LEN);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(CYC_LEN - 1);
  localparam logic [CNT_W-1:0] XFER_C  = CNT_W'(XFER_AT);
  localparam logic [CNT_W-1:0] HI_C    = CNT_W'(HI_SLOTS);
  localparam logic [CNT_W-1:0] STB_C   = CNT_W'(HI_SLOTS - 1);
  localparam logic [CNT_W-1:0] RD_ON_C = CNT_W'(XFER_AT - RD_LEAD);
  localparam logic [CNT_W-1:0] WR_ON_C = CNT_W'(XFER_AT - WR_LEAD);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q;
  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      wr_q    <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      rd_data <= '0;
    end else if (!active) begin
      if (cyc_req) begin
        active <= 1'b1;
        cnt    <= '0;
        wr_q   <= cyc_wr;
        hi_q   <= cyc_addr[ADDR_W-1:HALF_W];
        lo_q   <= cyc_addr[HALF_W-1:0];
      end
    end else begin
      if (cnt == LAST_C) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cnt == XFER_C && !wr_q)
        rd_data <= rd_in;
    end
  end

  assign bus_ad     = (active && cnt < HI_C) ? hi_q : lo_q;
  assign hi_stb     = active && cnt == STB_C;
  assign xfer_pulse = active && cnt == XFER_C;
  assign rd_line    = active && !wr_q && cnt >= RD_ON_C;
  assign wr_line    = active &&  wr_q && cnt >= WR_ON_C;
endmodule

// File: rtl/early_dir_bus_chk.sv
module early_dir_bus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_ad,
  input logic       hi_stb,
  input logic       rd_line,
  input logic       wr_line,
  input logic       xfer_pulse,
  input logic [7:0] rd_data
);
  logic [3:0] lead;
  logic [3:0] stab;
  logic [7:0] prev_ab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead    <= '0;
      stab    <= '0;
      prev_ab <= '0;
    end else begin
      lead    <= (rd_line || wr_line) ? ((lead == 4'hF) ? lead : lead + 1'b1) : '0;
      stab    <= (bus_ad == prev_ab) ? ((stab == 4'hF) ? stab : stab + 1'b1) : '0;
      prev_ab <= bus_ad;
    end
  end

  // R8
  excl_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_line && wr_line));
  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_pulse |=> !xfer_pulse);
  // R5
  pulse_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_pulse |-> (rd_line ^ wr_line));
  // R6
  rd_lead_chk: assert property (@(posedge clk) disable iff (!rst_n) (xfer_pulse && rd_line) |-> lead == 4'd5);
  // R7
  wr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n) (xfer_pulse && wr_line) |-> lead == 4'd2);
  // R4: three unchanged edges means four clocks of the same byte before the pulse
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_pulse |-> stab >= 4'd3);
  // R3
  hi_stb_len_chk: assert property (@(posedge clk) disable iff (!rst_n) hi_stb |=> !hi_stb);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$past(xfer_pulse) |-> $stable(rd_data));
endmodule

bind early_dir_bus early_dir_bus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .hi_stb(hi_stb), .rd_line(rd_line),
  .wr_line(wr_line), .xfer_pulse(xfer_pulse), .rd_data(rd_data)
);

// File: tb/tb_early_dir_bus.sv
module tb_early_dir_bus;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_req;
  logic        cyc_wr;
  logic [15:0] cyc_addr;
  logic [7:0]  rd_in;
  logic [7:0]  bus_ad;
  logic        hi_stb, rd_line, wr_line, xfer_pulse;
  logic [7:0]  rd_data;

  always #5 clk = ~clk;

  early_dir_bus dut (
    .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr),
    .rd_in(rd_in), .bus_ad(bus_ad), .hi_stb(hi_stb), .rd_line(rd_line), .wr_line(wr_line),
    .xfer_pulse(xfer_pulse), .rd_data(rd_data)
  );

  typedef struct {
    logic [15:0] a;
    bit          w;
    logic [7:0]  d;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor / scoreboard
  int rd_run, wr_run, lo_run, since_hi, post;
  logic [7:0] prev_ab, last_rd;
  item_t cur;

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_run = 0; wr_run = 0; lo_run = 0; since_hi = 0; post = 0;
      prev_ab = 8'h00; last_rd = 8'h00; rd_in = 8'h00;
    end else begin
      chk(!(rd_line && wr_line), "R8 exclusive", {rd_line, wr_line}, 0);
      rd_run   = rd_line ? rd_run + 1 : 0;
      wr_run   = wr_line ? wr_run + 1 : 0;
      lo_run   = (bus_ad == prev_ab) ? lo_run + 1 : 1;
      prev_ab  = bus_ad;
      since_hi = hi_stb ? 0 : since_hi + 1;
      if (hi_stb) begin
        if (q.size() == 0) chk(0, "R1 unexpected cycle", 1, 0);
        else begin
          chk(bus_ad == q[0].a[15:8], "R3 upper byte", bus_ad, q[0].a[15:8]);
          rd_in = ~q[0].d;
        end
      end
      if (post == 2) begin
        chk(!rd_line && !wr_line, "R8 lines drop", {rd_line, wr_line}, 0);
        chk(rd_data == last_rd, "R9 hold", rd_data, last_rd);
        post = 0;
      end
      if (post == 1) begin
        chk(!xfer_pulse, "R5 one clock", xfer_pulse, 0);
        chk(cur.w ? (wr_line && !rd_line) : (rd_line && !wr_line), "R8 held to end",
            {rd_line, wr_line}, cur.w ? 1 : 2);
        chk(rd_data == last_rd, "R9 capture", rd_data, last_rd);
        rd_in = ~cur.d;
        post = 2;
      end
      if (xfer_pulse) begin
        if (q.size() == 0) chk(0, "R1 unexpected pulse", 1, 0);
        else begin
          cur = q.pop_front();
          chk(bus_ad == cur.a[7:0], "R4 lower byte", bus_ad, cur.a[7:0]);
          chk(lo_run >= 5, "R4 stable", lo_run, 5);
          chk(since_hi == 5, "R2 slot", since_hi, 5);
          if (cur.w) begin
            chk(wr_run == 3, "R7 write lead", wr_run, 3);
            chk(rd_run == 0, "R7 no read", rd_run, 0);
          end else begin
            chk(rd_run == 6, "R6 read lead", rd_run, 6);
            chk(wr_run == 0, "R6 no write", wr_run, 0);
            last_rd = cur.d;
          end
          rd_in = cur.d;
          post = 1;
        end
      end
    end
  end

  task automatic run(input logic [15:0] a, input bit w, input logic [7:0] d);
    q.push_back('{a: a, w: w, d: d});
    @(negedge clk); cyc_req = 1'b1; cyc_addr = a; cyc_wr = w;
    @(negedge clk); cyc_req = 1'b0; cyc_addr = ~a; cyc_wr = ~w;
    repeat (9) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cyc_req = 1'b0; cyc_wr = 1'b0; cyc_addr = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ad == 8'h00, "R10 bus", bus_ad, 0);
    chk(!hi_stb, "R10 strobe", hi_stb, 0);
    chk(!rd_line && !wr_line, "R10 lines", {rd_line, wr_line}, 0);
    chk(!xfer_pulse, "R10 pulse", xfer_pulse, 0);
    chk(rd_data == 8'h00, "R10 data", rd_data, 0);

    run(16'h12AB, 0, 8'h5A);
    run(16'hFE01, 1, 8'hC3);
    run(16'h0000, 0, 8'hFF);
    run(16'hFFFF, 1, 8'h00);
    run(16'h3C3C, 0, 8'h81);
    chk(bus_ad == 8'h3C, "R4 idle hold", bus_ad, 8'h3C);

    // R1: request during a running cycle is ignored
    q.push_back('{a: 16'hA55A, w: 0, d: 8'h69});
    @(negedge clk); cyc_req = 1'b1; cyc_addr = 16'hA55A; cyc_wr = 1'b0;
    @(negedge clk); cyc_req = 1'b0;
    repeat (2) @(negedge clk); cyc_req = 1'b1; cyc_addr = 16'h5555; cyc_wr = 1'b1;
    repeat (2) @(negedge clk); cyc_req = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!hi_stb && !xfer_pulse, "R1 ignored request", {hi_stb, xfer_pulse}, 0);
    end
    chk(q.size() == 0, "R1 queue drained", q.size(), 0);

    // R2: request held high, second cycle follows the first
    q.push_back('{a: 16'h8421, w: 0, d: 8'h17});
    @(negedge clk); cyc_req = 1'b1; cyc_addr = 16'h8421; cyc_wr = 1'b0;
    @(negedge clk); cyc_addr = 16'h7E18; cyc_wr = 1'b1;
    q.push_back('{a: 16'h7E18, w: 1, d: 8'hE2});
    repeat (9) @(negedge clk); cyc_req = 1'b0;
    repeat (12) @(negedge clk);
    chk(q.size() == 0, "R2 back to back", q.size(), 0);
    finish_run();
  end
endmodule